// File: doc/BRIEF.md
# Bit-Sliced Maximum Selector

This block returns the larger of two unsigned operands. It does not use a magnitude comparator followed by a multiplexer. The result comes from a chain of one-bit slices. Each slice takes one bit of each operand and two lead flags: "A is ahead" and "B is ahead", decided by the bits above it. From these it produces one bit of the maximum and the updated flags. While neither flag is set, the operands agree so far, so the output bit is the OR of the two current bits. That value equals either bit when they match, and it is the winner's bit when they first differ. Once a flag is set, the output copies the leading operand.

Because each output bit depends only on the flags and the current bit pair, the same slice also works one bit per clock, most significant bit first, with no operand storage. The serial port has three parts:

- **Flag register and bit counter.** These store the slice's flags and count the bits of the operation.
- **Start strobe.** Held high together with the MSB, it makes the slice see cleared flags for that bit.
- **Controller.** A three-state machine sequences the operation:
  - `ST_IDLE` is the state after reset.
  - `ST_SCAN` is active while bits arrive.
  - `ST_HOLD` is entered after the last bit, and the flags stay frozen there.
  - Transitions: start moves any state to `ST_SCAN`, or straight to `ST_HOLD` when the width is one. `ST_SCAN` moves to `ST_HOLD` on the last bit. `ST_IDLE` and `ST_HOLD` stay put without a start.

Top module: `maxsel_top`

## Requirements
- R1: `par_max` equals the larger of the unsigned operands `par_a` and `par_b` for every pair.
- R2: Each parallel output bit is chosen by the lead decided from the higher bits, not by the current pair alone. For example, at 4 bits, A=1000 and B=0111 give 1000, not 1111.
- R3: When the operands are equal, `par_max` equals that common value.
- R4: In serial mode, `ser_max` in each cycle is the matching bit of the maximum of the serial operands. It is combinational from `ser_a`, `ser_b` and the stored flags, so it appears in the same cycle as its input bits, MSB first.
- R5: A cycle with `ser_start` high treats the flags as cleared for that bit, so `ser_max` is `ser_a | ser_b`. This restarts the operation even in the middle of a previous one.
- R6: `ser_done` is high exactly in the cycle where the WIDTH-th bit after a start is presented, and low otherwise.
- R7: After that last bit, the flags hold until the next start. While holding, `ser_max` follows `ser_a` if A led, follows `ser_b` if B led, and is `ser_a | ser_b` if they tied.
- R8: Under and right after reset, `ser_done` is low and the flags are clear, so `ser_max` is `ser_a | ser_b`.
- R9: The two serial lead flags are never both set, and once one is set it stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the serial path |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_a | input | WIDTH | Parallel operand A |
| par_b | input | WIDTH | Parallel operand B |
| par_max | output | WIDTH | Larger of `par_a` and `par_b` |
| ser_start | input | 1 | High together with the MSB of a serial operation |
| ser_a | input | 1 | Current bit of serial operand A |
| ser_b | input | 1 | Current bit of serial operand B |
| ser_max | output | 1 | Current bit of the serial maximum |
| ser_done | output | 1 | High in the cycle of the last serial bit |

## Verification
The assertions check on every cycle the following properties:
- The parallel result equals the unsigned maximum, and its final lead agrees with the magnitude order.
- A start bit yields the OR of its two inputs.
- The serial flags stay exclusive and sticky.
- A set flag makes the serial output copy the leading operand.
- The flags are frozen in the hold state.
- A done pulse is never followed by a second one without a new start.

The bench scenarios show the following, which no single-cycle property can:
- Every serial bit of a full operation is correct, MSB first.
- Done lands on exactly the WIDTH-th bit.
- A restart in the middle of an operation discards the old lead.
- The held lead is still visible on the output several cycles after the end.

// File: rtl/maxsel_pkg.sv
package maxsel_pkg;

    // Lead flags carried from higher to lower bits.
    typedef struct packed {
        logic a_ahead;
        logic b_ahead;
    } lead_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } ser_state_t;

endpackage

// File: rtl/maxsel_slice.sv
module maxsel_slice
    import maxsel_pkg::*;
(
    input  logic  a_bit,
    input  logic  b_bit,
    input  lead_t lead_in,
    output logic  m_bit,
    output lead_t lead_out
);
    logic tied;

    always_comb begin
        tied  = ~lead_in.a_ahead & ~lead_in.b_ahead;
        m_bit = (lead_in.a_ahead & a_bit)
              | (lead_in.b_ahead & b_bit)
              | (tied & (a_bit | b_bit));
        lead_out.a_ahead = lead_in.a_ahead | (~lead_in.b_ahead & a_bit & ~b_bit);
        lead_out.b_ahead = lead_in.b_ahead | (~lead_in.a_ahead & ~a_bit & b_bit);
    end
endmodule

// File: rtl/maxsel_chain.sv
module maxsel_chain
    import maxsel_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] op_max,
    output lead_t            final_lead
);
    // lead[i+1] enters slice i; lead[WIDTH] enters the MSB slice.
    lead_t lead [WIDTH:0];

    assign lead[WIDTH] = '0;

    for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_slice
        maxsel_slice u_slice (
            .a_bit    (op_a[i]),
            .b_bit    (op_b[i]),
            .lead_in  (lead[i+1]),
            .m_bit    (op_max[i]),
            .lead_out (lead[i])
        );
    end

    assign final_lead = lead[0];
endmodule

// File: rtl/maxsel_serial.sv
module maxsel_serial
    import maxsel_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       a_bit,
    input  logic       b_bit,
    output logic       m_bit,
    output logic       done,
    output lead_t      lead_q,
    output ser_state_t state_q
);
    localparam int          CW   = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    ser_state_t    state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    lead_t         lead_d, lead_use, lead_nxt;

    assign lead_use = start ? lead_t'('0) : lead_q;

    maxsel_slice u_bit (
        .a_bit    (a_bit),
        .b_bit    (b_bit),
        .lead_in  (lead_use),
        .m_bit    (m_bit),
        .lead_out (lead_nxt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lead_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lead_q  <= lead_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lead_d  = lead_q;
        if (start) begin
            lead_d  = lead_nxt;
            cnt_d   = ONE;
            state_d = (WIDTH == 1) ? ST_HOLD : ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: ;
                ST_SCAN: begin
                    lead_d = lead_nxt;
                    cnt_d  = cnt_q + ONE;
                    if (cnt_q == LAST) state_d = ST_HOLD;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done = 1'b0;
        if (start) begin
            done = (WIDTH == 1);
        end else begin
            unique case (state_q)
                ST_SCAN:          done = (cnt_q == LAST);
                ST_IDLE, ST_HOLD: done = 1'b0;
                default:          done = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/maxsel_top.sv
module maxsel_top
    import maxsel_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_a,
    input  logic [WIDTH-1:0] par_b,
    output logic [WIDTH-1:0] par_max,
    input  logic             ser_start,
    input  logic             ser_a,
    input  logic             ser_b,
    output logic             ser_max,
    output logic             ser_done
);
    lead_t      par_lead;
    lead_t      ser_lead;
    ser_state_t ser_state;

    maxsel_chain #(.WIDTH(WIDTH)) u_chain (
        .op_a       (par_a),
        .op_b       (par_b),
        .op_max     (par_max),
        .final_lead (par_lead)
    );

    maxsel_serial #(.WIDTH(WIDTH)) u_serial (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ser_start),
        .a_bit   (ser_a),
        .b_bit   (ser_b),
        .m_bit   (ser_max),
        .done    (ser_done),
        .lead_q  (ser_lead),
        .state_q (ser_state)
    );
endmodule

// File: rtl/maxsel_check.sv
module maxsel_check
    import maxsel_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] par_a,
    input logic [WIDTH-1:0] par_b,
    input logic [WIDTH-1:0] par_max,
    input lead_t            par_lead,
    input logic             ser_start,
    input logic             ser_a,
    input logic             ser_b,
    input logic             ser_max,
    input logic             ser_done,
    input lead_t            ser_lead,
    input ser_state_t       ser_state
);
    AST_PAR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        par_max == ((par_a > par_b) ? par_a : par_b)); // R1
    AST_PAR_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (par_lead.a_ahead == (par_a > par_b)) && (par_lead.b_ahead == (par_a < par_b))); // R2
    AST_PAR_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (par_a == par_b) |-> (par_max == par_a)); // R3
    AST_SER_FOLLOW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_lead.a_ahead && !ser_start) |-> (ser_max == ser_a)); // R4
    AST_SER_FOLLOW_B: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_lead.b_ahead && !ser_start) |-> (ser_max == ser_b)); // R4
    AST_START_OR: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> (ser_max == (ser_a | ser_b))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_done |=> (!ser_done || ser_start)); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_state == ST_HOLD && !ser_start) |=> $stable(ser_lead)); // R7
    AST_LEAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ser_lead.a_ahead, ser_lead.b_ahead})); // R9
    AST_LEAD_STICKY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_lead.a_ahead && !ser_start) |=> ser_lead.a_ahead); // R9
    AST_LEAD_STICKY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_lead.b_ahead && !ser_start) |=> ser_lead.b_ahead); // R9
endmodule

bind maxsel_top maxsel_check #(.WIDTH(WIDTH)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_a     (par_a),
    .par_b     (par_b),
    .par_max   (par_max),
    .par_lead  (par_lead),
    .ser_start (ser_start),
    .ser_a     (ser_a),
    .ser_b     (ser_b),
    .ser_max   (ser_max),
    .ser_done  (ser_done),
    .ser_lead  (ser_lead),
    .ser_state (ser_state)
);

// File: tb/maxsel_top_test.sv
module maxsel_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;

    // WIDTH=4 instance
    logic [3:0] a4 = '0, b4 = '0, m4;
    logic s_start4 = 1'b0, sa4 = 1'b0, sb4 = 1'b0, sm4, sd4;
    // WIDTH=32 instance
    logic [31:0] a32 = '0, b32 = '0, m32;
    logic s_start32 = 1'b0, sa32 = 1'b0, sb32 = 1'b0, sm32, sd32;

    maxsel_top #(.WIDTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .par_a(a4), .par_b(b4), .par_max(m4),
        .ser_start(s_start4), .ser_a(sa4), .ser_b(sb4), .ser_max(sm4), .ser_done(sd4)
    );

    maxsel_top #(.WIDTH(32)) uut_w (
        .clk(clk), .rst_n(rst_n), .par_a(a32), .par_b(b32), .par_max(m32),
        .ser_start(s_start32), .ser_a(sa32), .ser_b(sb32), .ser_max(sm32), .ser_done(sd32)
    );

    // {a, b, expected max}
    localparam logic [11:0] VEC [0:8] = '{
        {4'h8, 4'h7, 4'h8},
        {4'h7, 4'h8, 4'h8},
        {4'h5, 4'h5, 4'h5},
        {4'h0, 4'h0, 4'h0},
        {4'hF, 4'h0, 4'hF},
        {4'h0, 4'hF, 4'hF},
        {4'hA, 4'h5, 4'hA},
        {4'h3, 4'hC, 4'hC},
        {4'h6, 4'h9, 4'h9}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ser4(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] exp;
        exp = (a > b) ? a : b;
        for (int k = 3; k >= 0; k--) begin
            @(negedge clk);
            s_start4 = (k == 3);
            sa4 = a[k];
            sb4 = b[k];
            #1;
            chk("R4 serial bit", 64'(sm4), 64'(exp[k]));
            chk("R6 done timing", 64'(sd4), 64'(k == 0));
        end
        // hold phase: probe held lead
        @(negedge clk);
        s_start4 = 1'b0; sa4 = 1'b1; sb4 = 1'b0;
        #1;
        chk("R7 hold a=1 b=0", 64'(sm4), 64'((a < b) ? 1'b0 : 1'b1));
        chk("R6 no done in hold", 64'(sd4), 64'd0);
        @(negedge clk);
        sa4 = 1'b0; sb4 = 1'b1;
        #1;
        chk("R7 hold a=0 b=1", 64'(sm4), 64'((a > b) ? 1'b0 : 1'b1));
    endtask

    task automatic ser32(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] got;
        int dones;
        int last_k;
        dones = 0;
        last_k = -1;
        got = '0;
        for (int k = 31; k >= 0; k--) begin
            @(negedge clk);
            s_start32 = (k == 31);
            sa32 = a[k];
            sb32 = b[k];
            #1;
            got[k] = sm32;
            if (sd32) begin
                dones++;
                last_k = k;
            end
        end
        @(negedge clk);
        s_start32 = 1'b0;
        chk("R4 serial word 32", 64'(got), 64'((a > b) ? a : b));
        chk("R6 done count 32", 64'(dones), 64'd1);
        chk("R6 done on last bit 32", 64'(last_k), 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R8: reset state
        sa4 = 1'b1; sb4 = 1'b0;
        #2;
        chk("R8 done in reset", 64'(sd4), 64'd0);
        chk("R8 or in reset a", 64'(sm4), 64'd1);
        sa4 = 1'b0; sb4 = 1'b1;
        #1;
        chk("R8 or in reset b", 64'(sm4), 64'd1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sa4 = 1'b0; sb4 = 1'b0;
        #1;
        chk("R8 idle zero", 64'(sm4), 64'd0);
        chk("R8 idle done", 64'(sd4), 64'd0);

        // R2: vector table
        foreach (VEC[i]) begin
            a4 = VEC[i][11:8];
            b4 = VEC[i][7:4];
            #1;
            chk("R2 table", 64'(m4), 64'(VEC[i][3:0]));
        end

        // R1 / R3: exhaustive parallel at 4 bits
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                a4 = 4'(i);
                b4 = 4'(j);
                #1;
                chk((i == j) ? "R3 equal" : "R1 exhaustive", 64'(m4), 64'((i > j) ? i : j));
            end
        end

        // R4 / R6 / R7: exhaustive serial at 4 bits
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                ser4(4'(i), 4'(j));
            end
        end

        // R5: restart in the middle of an operation
        @(negedge clk);
        s_start4 = 1'b1; sa4 = 1'b1; sb4 = 1'b0;
        @(negedge clk);
        s_start4 = 1'b0; sa4 = 1'b0; sb4 = 1'b0;
        @(negedge clk);
        s_start4 = 1'b1; sa4 = 1'b0; sb4 = 1'b1;
        #1;
        chk("R5 restart or", 64'(sm4), 64'd1);
        chk("R5 restart no done", 64'(sd4), 64'd0);
        @(negedge clk);
        s_start4 = 1'b0; sa4 = 1'b1; sb4 = 1'b0;
        #1;
        chk("R5 new lead b", 64'(sm4), 64'd0);
        @(negedge clk);
        sa4 = 1'b1; sb4 = 1'b0;
        #1;
        chk("R5 new lead b bit1", 64'(sm4), 64'd0);
        chk("R6 no early done", 64'(sd4), 64'd0);
        @(negedge clk);
        sa4 = 1'b0; sb4 = 1'b1;
        #1;
        chk("R5 new lead b bit0", 64'(sm4), 64'd1);
        chk("R6 done after restart", 64'(sd4), 64'd1);

        // R1: random parallel at 32 bits
        for (int n = 0; n < 200; n++) begin
            a32 = $urandom();
            b32 = (n % 10 == 0) ? a32 : $urandom();
            #1;
            chk("R1 random 32", 64'(m32), 64'((a32 > b32) ? a32 : b32));
        end

        // R4 / R6: random serial at 32 bits, including near-equal operands
        for (int n = 0; n < 12; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = (n < 4) ? (ra ^ (32'h1 << n)) : $urandom();
            ser32(ra, rb);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule